// File: doc/BRIEF.md
# Periodic Reload Timer

This block is a free-running countdown timer shared by a cluster. It counts a fixed reference tick, which reaches it as a one-cycle tick-enable strobe. Software programs a reload count and turns the timer on. Each time that many ticks have passed, the block raises a sticky expiry flag and starts the same count again, so it fires at a steady period. The flag, gated by an interrupt-enable bit, drives a level interrupt request. Where that request is routed is outside this block.

Software reaches the timer through two words, selected by `bus_sel`. The control word (select 0) holds the count, the run bit, the interrupt-enable bit and the flag. The acknowledge word (select 1) only takes action bits and always reads as zero. One bit of the acknowledge word clears the flag. Another restarts the count, and it does so only while the timer runs.

A two-state machine sets the run/stop behaviour:
- In state IDLE the counter is held.
- In state RUN the counter moves down on each tick.
- START (IDLE to RUN) is a control write with the run bit set.
- STOP (RUN to IDLE) is a control write with the run bit clear.
- Inside RUN there are two self-loops. RELOAD is a control write with the run bit set, or an acknowledge restart, and it reloads the count. EXPIRE is a tick that finds the count at one; it sets the flag and reloads the count.

Top module: `ptmr_top`

## Requirements
- R1: After reset, the control word reads 0x00000000 and `irq` is low.
- R2: A control write keeps write bits [27:0] as the reload count, bit 28 as run and bit 29 as interrupt enable. Bits 31 and 30 of the write data are ignored: the flag keeps its value, and bit 30 of the control word always reads 0.
- R3: A control write with bit 28 set loads the count. The flag then rises on the clock edge that takes the Nth tick strobe after the write, where N is the reload count.
- R4: On expiry, bit 31 of the control word (the flag) is set and the count restarts from the reload value. The flag therefore rises again every N ticks.
- R5: While bit 28 reads 0, tick strobes never set the flag.
- R6: An acknowledge write (select 1) with bit 31 set clears the flag.
- R7: An acknowledge write with bit 30 set restarts the count from the reload value if the timer runs. If the timer is stopped, it has no effect.
- R8: The acknowledge word (select 1) reads as zero.
- R9: `irq` is high exactly when the flag and bit 29 are both set.
- R10: If an expiry and a flag-clear acknowledge fall in the same cycle, the flag stays set.
- R11: If a tick strobe falls in the same cycle as a control write or an acknowledge restart, the load wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle reference tick strobe |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_sel | input | 1 | Word select: 0 control, 1 acknowledge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level interrupt request |

## Verification
The checks assume that the timer never runs with a reload count of zero. The design treats such a count as one, and the checks do not cover that case; every run-bit write in the stimulus uses a count of one or more. The checks also assume that `bus_wr` lasts one cycle per access. The stimulus drives writes as single-cycle pulses on the falling edge. Tick strobes are sometimes placed in the same cycle as a write to reach the collision cases, R10 and R11.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int WORD_W   = 32;
    localparam int EN_BIT   = 28;
    localparam int IE_BIT   = 29;
    localparam int RLD_BIT  = 30;
    localparam int FLAG_BIT = 31;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_ACK  = 1'b1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/ptmr_fsm.sv
module ptmr_fsm
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_en,
    input  logic ack_reload,
    output logic run,
    output logic load
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: START, STOP; RELOAD and EXPIRE stay in RUN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_wr && ctrl_en)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !ctrl_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run  = 1'b0;
        load = 1'b0;
        unique case (state_q)
            ST_IDLE: load = ctrl_wr && ctrl_en;
            ST_RUN: begin
                run  = 1'b1;
                load = (ctrl_wr && ctrl_en) || ack_reload;
            end
            default: begin
                run  = 1'b0;
                load = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d;

    assign expire = run && tick && !load && (count <= ONE);

    always_comb begin
        count_d = count;
        if (load)             count_d = load_val;
        else if (expire)      count_d = reload_val;
        else if (run && tick) count_d = count - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    logic             ctrl_wr, ack_wr, ack_clr, ack_rld;
    logic             run, load, expire;
    logic [CNT_W-1:0] count, reload_q, load_val;
    logic             ie_q, flag_q;
    logic [WORD_W-1:0] ctrl_word;

    assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
    assign ack_wr  = bus_wr && (bus_sel == SEL_ACK);
    assign ack_clr = ack_wr && bus_wdata[FLAG_BIT];
    assign ack_rld = ack_wr && bus_wdata[RLD_BIT];

    ptmr_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_en    (bus_wdata[EN_BIT]),
        .ack_reload (ack_rld),
        .run        (run),
        .load       (load)
    );

    assign load_val = ctrl_wr ? bus_wdata[CNT_W-1:0] : reload_q;

    ptmr_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick_en),
        .load       (load),
        .load_val   (load_val),
        .reload_val (reload_q),
        .expire     (expire),
        .count      (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ie_q     <= 1'b0;
        end else if (ctrl_wr) begin
            reload_q <= bus_wdata[CNT_W-1:0];
            ie_q     <= bus_wdata[IE_BIT];
        end
    end

    // Expiry has priority over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (ack_clr) flag_q <= 1'b0;
    end

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[CNT_W-1:0]   = reload_q;
        ctrl_word[EN_BIT]      = run;
        ctrl_word[IE_BIT]      = ie_q;
        ctrl_word[FLAG_BIT]    = flag_q;
    end

    assign bus_rdata = (bus_sel == SEL_CTRL) ? ctrl_word : '0;
    assign irq       = flag_q && ie_q;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             load,
    input logic             tick,
    input logic             expire,
    input logic             ack_clr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_q,
    input logic             flag_q,
    input logic             irq
);
    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

    // R4
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    // R4
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload_q)));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !expire) |=> !flag_q);

    // R10
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && expire) |=> flag_q);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> !irq);
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .load     (load),
    .tick     (tick_en),
    .expire   (expire),
    .ack_clr  (ack_clr),
    .count    (count),
    .reload_q (reload_q),
    .flag_q   (flag_q),
    .irq      (irq)
);

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 17;

    typedef struct packed {
        logic        wr;
        logic        sel;
        logic [31:0] data;
        logic [7:0]  nticks;
        logic [31:0] exp_ctrl;
        logic        exp_irq;
    } row_t;

    // wr, sel, data, ticks after the write, expected control word, expected irq
    localparam row_t TABLE [NROWS] = '{
        '{1'b1, 1'b0, 32'h3000_0003, 8'd2, 32'h3000_0003, 1'b0}, // R3 not yet expired
        '{1'b0, 1'b0, 32'h0,         8'd1, 32'hB000_0003, 1'b1}, // R3 R4 R9 third tick
        '{1'b1, 1'b1, 32'h8000_0000, 8'd0, 32'h3000_0003, 1'b0}, // R6 clear
        '{1'b0, 1'b0, 32'h0,         8'd3, 32'hB000_0003, 1'b1}, // R4 periodic
        '{1'b1, 1'b1, 32'h8000_0000, 8'd2, 32'h3000_0003, 1'b0}, // R6
        '{1'b1, 1'b1, 32'h4000_0000, 8'd2, 32'h3000_0003, 1'b0}, // R7 restart
        '{1'b0, 1'b0, 32'h0,         8'd1, 32'hB000_0003, 1'b1}, // R7
        '{1'b1, 1'b0, 32'h1000_0005, 8'd0, 32'h9000_0005, 1'b0}, // R2 R9 ie off
        '{1'b1, 1'b1, 32'h8000_0000, 8'd4, 32'h1000_0005, 1'b0}, // R3 new count
        '{1'b1, 1'b0, 32'h2000_0005, 8'd5, 32'h2000_0005, 1'b0}, // R5 stopped
        '{1'b1, 1'b1, 32'h4000_0000, 8'd3, 32'h2000_0005, 1'b0}, // R7 R5 no effect
        '{1'b1, 1'b0, 32'h3000_0001, 8'd1, 32'hB000_0001, 1'b1}, // R3 count one
        '{1'b1, 1'b1, 32'hC000_0000, 8'd0, 32'h3000_0001, 1'b0}, // R6 R7 both
        '{1'b0, 1'b0, 32'h0,         8'd1, 32'hB000_0001, 1'b1}, // R4
        '{1'b1, 1'b1, 32'h8000_0000, 8'd0, 32'h3000_0001, 1'b0}, // R6
        '{1'b1, 1'b0, 32'hD000_0002, 8'd0, 32'h1000_0002, 1'b0}, // R2 bits 31,30 ignored
        '{1'b0, 1'b0, 32'h0,         8'd2, 32'h9000_0002, 1'b0}  // R4 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptmr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic sel, input logic [31:0] data, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic check_ctrl(input string req, input logic [31:0] exp_c, input logic exp_i);
        bus_sel = 1'b0;
        #1;
        check_val(req, bus_rdata, exp_c);
        check_val(req, {31'b0, irq}, {31'b0, exp_i});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_ctrl("R1 reset state", 32'h0, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            if (TABLE[i].wr) wr_word(TABLE[i].sel, TABLE[i].data, 1'b0);
            ticks(int'(TABLE[i].nticks));
            check_ctrl($sformatf("table row %0d", i), TABLE[i].exp_ctrl, TABLE[i].exp_irq);
        end

        // R8 acknowledge word reads zero while the flag is set
        bus_sel = 1'b1;
        #1;
        check_val("R8 ack readback", bus_rdata, 32'h0);

        // R10 expiry and clear in the same cycle
        wr_word(1'b0, 32'h3000_0001, 1'b0);
        check_ctrl("R2 flag kept on control write", 32'hB000_0001, 1'b1);
        wr_word(1'b1, 32'h8000_0000, 1'b1);
        check_ctrl("R10 expiry beats clear", 32'hB000_0001, 1'b1);
        wr_word(1'b1, 32'h8000_0000, 1'b0);
        check_ctrl("R6 clear alone", 32'h3000_0001, 1'b0);

        // R11 load wins over a tick in the same cycle
        wr_word(1'b0, 32'h3000_0004, 1'b1);
        ticks(3);
        check_ctrl("R11 tick dropped on load", 32'h3000_0004, 1'b0);
        ticks(1);
        check_ctrl("R11 expiry after full count", 32'hB000_0004, 1'b1);
        wr_word(1'b1, 32'h8000_0000, 1'b0);
        ticks(1);
        wr_word(1'b1, 32'h4000_0000, 1'b1);
        ticks(3);
        check_ctrl("R11 tick dropped on restart", 32'h3000_0004, 1'b0);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_ctrl("R1 reset mid-run", 32'h0, 1'b0);
        rst_n = 1'b1;
        ticks(6);
        check_ctrl("R5 idle after reset", 32'h0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule